// File: doc/BRIEF.md
# Converter Calibration Scheduler

This block decides when the data converter recalibrates itself. After reset, and again after every power-fail indication, it holds the converter busy through a long settling wait so that the supplies and reference can settle. It then runs a fixed-length calibration phase and follows it with one forced normal conversion. Once that conversion is done, the converter is released for ordinary use.

Software or the board can also ask for calibration at any time. There are two ways to do this. One is a low pulse on an active-low calibration pin, which takes effect on the pulse's closing rising edge. The other is writing a one to bit 1 of an 8-bit control register. A request is honoured even when a conversion is running: the block tells the conversion sequencer to abort, then gates off user convert commands for as long as calibration lasts.

The block sits between the host interface and the conversion sequencer. It forwards user convert commands to the sequencer only when idle and drives the active-low busy flag that the host polls. The correction arithmetic done during calibration lives elsewhere. Here only the phase timing and the hand-off are produced.

Top module: `cal_scheduler`

## Requirements
- R1: When reset is released, `busy_n` stays low and `conv_inhibit` first rises after exactly SETTLE_CYCLES (default 42425) clock edges.
- R2: While `pwr_fail` is high the block holds the settling wait at its start, with `conv_inhibit` low and `busy_n` low. After `pwr_fail` falls, calibration begins SETTLE_CYCLES edges later, whatever phase the block was in before.
- R3: The calibration phase, during which `conv_inhibit` is high, lasts CAL_CYCLES (default 168) cycles.
- R4: In the first cycle after calibration ends, `conv_start` pulses for one cycle. `busy_n` then rises exactly CONV_CYCLES (default 17) cycles after calibration ended.
- R5: `busy_n` is low during reset, the settling wait, calibration and the appended conversion. When idle, it is low exactly while `conv_busy` is high.
- R6: The calibration pin `cal_n` is synchronised through SYNC_STAGES (default 2) flops. A low pulse lasting at least CAL_MIN_LOW (default 10) cycles starts calibration, with `conv_inhibit` high in the third cycle after the pin rises. A shorter low pulse is ignored.
- R7: A write with `ctl_wdata` bit 1 set makes `ctl_rdata` bit 1 read 1 for one cycle. That bit then clears by itself as the request is accepted, and calibration begins on the same edge. A write with bit 1 clear starts nothing. The other seven bits hold the value last written.
- R8: A request that arrives during calibration restarts the calibration count. `conv_inhibit` stays high for CAL_CYCLES cycles counted from the edge that accepts it.
- R9: If a request is accepted while `conv_busy` is high, or during the appended conversion, `conv_abort` is high in the cycle the request is presented.
- R10: `conv_cmd` reaches `conv_start` in the same cycle only when the block is idle. During settling, calibration or the appended conversion it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_fail | input | 1 | Power-fail indication, active high |
| cal_n | input | 1 | Asynchronous calibration pin, active-low pulse |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data; bit 1 requests calibration |
| ctl_rdata | output | 8 | Control register read-back |
| conv_cmd | input | 1 | User convert command |
| conv_busy | input | 1 | Conversion sequencer is converting |
| conv_start | output | 1 | Start pulse to the conversion sequencer |
| conv_abort | output | 1 | Abort to the conversion sequencer |
| conv_inhibit | output | 1 | High during calibration; convert commands are blocked |
| busy_n | output | 1 | Busy flag, active low |

## Verification
The phase timing is measured edge by edge along three paths: after reset release, after a power-fail mid-calibration, and after the two kinds of user request. Each path shows whether the settle, calibration and appended-conversion counters start from the right place. Pin pulses are swept across widths on either side of the minimum. This separates an off-by-one in the glitch filter from a faulty synchroniser latency. Requests are also made during calibration, during a running conversion and during the appended conversion, which sets the restart behaviour apart from the abort behaviour.

// File: rtl/cal_sched_pkg.sv
package cal_sched_pkg;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_CAL    = 2'd1,
    PH_CONV   = 2'd2,
    PH_IDLE   = 2'd3
  } phase_t;

  // a span of len cycles counted from zero ends when the count reaches len-1
  function automatic logic span_done(input logic [31:0] cnt, input logic [31:0] len);
    return cnt == (len - 32'd1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cal_pin_filter.sv
module cal_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic evt
);
  localparam int unsigned LW = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] chain;
  logic                   synced;
  logic                   synced_d;
  logic [LW-1:0]          low_cnt;
  logic                   wide_enough;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= pin_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2:0], pin_n};
    end
  endgenerate

  assign synced = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_d <= 1'b1;
      low_cnt  <= '0;
    end else begin
      synced_d <= synced;
      if (synced)                          low_cnt <= '0;
      else if (low_cnt != LW'(MIN_LOW))    low_cnt <= low_cnt + 1'b1;
    end
  end

  assign wide_enough = (low_cnt == LW'(MIN_LOW));
  assign evt         = synced & ~synced_d & wide_enough;

  p_evt_after_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(!synced));

endmodule

// File: rtl/cal_ctl_reg.sv
module cal_ctl_reg #(
  parameter int unsigned DW      = 8,
  parameter int unsigned REQ_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          pend,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] held;
  logic          set_req;

  assign set_req = wr & wdata[REQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      pend <= 1'b0;
    end else begin
      if (wr) held <= wdata;
      pend <= set_req;   // accepted on the edge after it is set, so it drops itself
    end
  end

  always_comb begin
    rdata          = held;
    rdata[REQ_BIT] = pend;
  end

  p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !set_req) |=> !pend);

endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer
  import cal_sched_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 42425,
  parameter int unsigned CAL_CYCLES    = 168,
  parameter int unsigned CONV_CYCLES   = 17
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold_settle,
  input  logic   start_cal,
  output phase_t phase,
  output logic   settle_done,
  output logic   cal_done,
  output logic   conv_first,
  output logic   conv_done
);
  localparam int unsigned LONGEST = max3(SETTLE_CYCLES, CAL_CYCLES, CONV_CYCLES);
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  logic [CW-1:0] cnt;

  assign settle_done = (phase == PH_SETTLE) && span_done(32'(cnt), SETTLE_CYCLES);
  assign cal_done    = (phase == PH_CAL)    && span_done(32'(cnt), CAL_CYCLES);
  assign conv_done   = (phase == PH_CONV)   && span_done(32'(cnt), CONV_CYCLES);
  assign conv_first  = (phase == PH_CONV)   && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SETTLE;
      cnt   <= '0;
    end else if (hold_settle) begin
      phase <= PH_SETTLE;
      cnt   <= '0;
    end else if (start_cal) begin
      phase <= PH_CAL;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_SETTLE: if (settle_done) begin phase <= PH_CAL;  cnt <= '0; end
                   else cnt <= cnt + 1'b1;
        PH_CAL:    if (cal_done)    begin phase <= PH_CONV; cnt <= '0; end
                   else cnt <= cnt + 1'b1;
        PH_CONV:   if (conv_done)   begin phase <= PH_IDLE; cnt <= '0; end
                   else cnt <= cnt + 1'b1;
        PH_IDLE:   cnt <= '0;
        default:   begin phase <= PH_SETTLE; cnt <= '0; end
      endcase
    end
  end

  p_settle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_settle |=> (phase == PH_SETTLE && cnt == '0));

  p_cal_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cal && !hold_settle) |=> (phase == PH_CAL && cnt == '0));

  p_cal_to_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !hold_settle && !start_cal) |=> conv_first);

  p_settle_to_cal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_done && !hold_settle) |=> (phase == PH_CAL));

  p_cal_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CAL) |-> (cnt < CW'(CAL_CYCLES)));

endmodule

// File: rtl/cal_scheduler.sv
module cal_scheduler
  import cal_sched_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 42425,
  parameter int unsigned CAL_CYCLES    = 168,
  parameter int unsigned CONV_CYCLES   = 17,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned CAL_MIN_LOW   = 10,
  parameter int unsigned CTL_W         = 8,
  parameter int unsigned CTL_REQ_BIT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_fail,
  input  logic             cal_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             conv_cmd,
  input  logic             conv_busy,
  output logic             conv_start,
  output logic             conv_abort,
  output logic             conv_inhibit,
  output logic             busy_n
);
  phase_t phase;
  logic   pin_evt;
  logic   reg_pend;
  logic   cal_req;
  logic   cal_take;
  logic   settle_done, cal_done, conv_first, conv_done;
  logic   in_idle;

  cal_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(CAL_MIN_LOW)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(cal_n), .evt(pin_evt)
  );

  cal_ctl_reg #(.DW(CTL_W), .REQ_BIT(CTL_REQ_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .pend(reg_pend), .rdata(ctl_rdata)
  );

  // requests landing in the settling wait merge into the coming calibration
  assign cal_req  = pin_evt | reg_pend;
  assign cal_take = cal_req & ~pwr_fail & (phase != PH_SETTLE);

  cal_phase_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES), .CAL_CYCLES(CAL_CYCLES), .CONV_CYCLES(CONV_CYCLES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_settle(pwr_fail), .start_cal(cal_take),
    .phase(phase), .settle_done(settle_done), .cal_done(cal_done),
    .conv_first(conv_first), .conv_done(conv_done)
  );

  assign in_idle      = (phase == PH_IDLE);
  assign conv_inhibit = (phase == PH_CAL);
  assign conv_start   = conv_first | (conv_cmd & in_idle);
  assign conv_abort   = cal_take & (conv_busy | (phase == PH_CONV));
  assign busy_n       = rst_n & in_idle & ~conv_busy;

  p_inhibit_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_inhibit |-> !busy_n);

  p_no_cmd_in_cal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_inhibit |-> !conv_start);

  p_abort_to_cal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_abort && !pwr_fail) |=> conv_inhibit);

  p_release_after_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !pwr_fail && !cal_take) |=> (busy_n == !conv_busy));

endmodule

// File: tb/cal_scheduler_test.sv
module cal_scheduler_test;
  localparam int unsigned SETTLE = 42425;
  localparam int unsigned CALN   = 168;
  localparam int unsigned CONVN  = 17;
  localparam int unsigned MINLOW = 10;
  localparam int unsigned NV     = 7;
  localparam int unsigned PW  [NV] = '{1, 5, 9, 10, 11, 30, 2};
  localparam bit          ACC [NV] = '{0, 0, 0, 1,  1,  1,  0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       cal_n = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       conv_cmd = 1'b0;
  logic       conv_busy = 1'b0;
  logic       conv_start, conv_abort, conv_inhibit, busy_n;

  int compared = 0;
  int mismatched = 0;
  bit watch_busy = 1'b0;
  bit busy_seen_high = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cal_scheduler uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .cal_n(cal_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .conv_cmd(conv_cmd), .conv_busy(conv_busy), .conv_start(conv_start),
    .conv_abort(conv_abort), .conv_inhibit(conv_inhibit), .busy_n(busy_n)
  );

  always @(negedge clk)
    if (watch_busy && busy_n) busy_seen_high = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel 0: conv_inhibit, sel 1: busy_n; counts negedges until it equals val
  task automatic count_until(input int sel, input bit val, output int n);
    n = 0;
    for (int i = 0; i < 50000; i++) begin
      @(negedge clk);
      n++;
      if ((sel == 0 ? conv_inhibit : busy_n) == val) return;
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic settle_idle();
    int n;
    count_until(1, 1'b1, n);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    // reset state (R5)
    repeat (3) @(negedge clk);
    check(busy_n == 1'b0, "R5 busy in reset", busy_n, 0);
    check(conv_inhibit == 1'b0 && conv_start == 1'b0 && conv_abort == 1'b0,
          "R5 outputs quiet in reset", conv_inhibit, 0);
    check(ctl_rdata == 8'h00, "R7 register reset", ctl_rdata, 0);

    // power-up: settle wait, calibration, appended conversion (R1 R3 R4 R5)
    rst_n = 1'b1;
    watch_busy = 1'b1;
    count_until(0, 1'b1, n);
    check(n == SETTLE, "R1 settle length", n, SETTLE);
    conv_cmd = 1'b1; #1;
    check(conv_start == 1'b0, "R10 command ignored in calibration", conv_start, 0);
    conv_cmd = 1'b0;
    count_until(0, 1'b0, n);
    check(n == CALN, "R3 calibration length", n, CALN);
    check(conv_start == 1'b1, "R4 forced start pulse", conv_start, 1);
    conv_cmd = 1'b1; #1;
    check(conv_start == 1'b1, "R10 command during appended conversion is dropped (start is forced only)",
          conv_start, 1);
    @(negedge clk); #1;
    check(conv_start == 1'b0, "R10 command ignored in appended conversion", conv_start, 0);
    conv_cmd = 1'b0;
    count_until(1, 1'b1, n);
    check(n + 1 == CONVN, "R4 appended conversion length", n + 1, CONVN);
    watch_busy = 1'b0;
    check(busy_seen_high == 1'b0, "R5 busy held low throughout", busy_seen_high, 0);
    conv_cmd = 1'b1; #1;
    check(conv_start == 1'b1, "R10 command forwarded when idle", conv_start, 1);
    conv_cmd = 1'b0;
    conv_busy = 1'b1; #1;
    check(busy_n == 1'b0, "R5 busy follows sequencer", busy_n, 0);
    conv_busy = 1'b0; #1;
    check(busy_n == 1'b1, "R5 busy released", busy_n, 1);

    // pin pulse widths (R6)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cal_n = 1'b0;
      repeat (PW[v]) @(negedge clk);
      cal_n = 1'b1;
      repeat (2) @(negedge clk);
      check(conv_inhibit == 1'b0, "R6 no early start", conv_inhibit, 0);
      @(negedge clk);
      check(conv_inhibit == ACC[v], "R6 pulse width filter", conv_inhibit, int'(ACC[v]));
      repeat (4) @(negedge clk);
      if (!ACC[v]) check(busy_n == 1'b1, "R6 short pulse ignored", busy_n, 1);
      settle_idle();
    end

    // register request (R7)
    reg_write(8'hA6);
    check(ctl_rdata == 8'hA6, "R7 request bit visible", ctl_rdata, 8'hA6);
    @(negedge clk);
    check(ctl_rdata == 8'hA4, "R7 request bit self-clears", ctl_rdata, 8'hA4);
    check(conv_inhibit == 1'b1, "R7 calibration started", conv_inhibit, 1);
    count_until(0, 1'b0, n);
    check(n == CALN, "R3 user calibration length", n, CALN);
    settle_idle();
    reg_write(8'hFD);
    repeat (3) @(negedge clk);
    check(ctl_rdata == 8'hFD, "R7 other bits held, bit 1 clear", ctl_rdata, 8'hFD);
    check(busy_n == 1'b1 && conv_inhibit == 1'b0, "R7 write without bit 1 ignored", busy_n, 1);

    // restart during calibration (R8)
    reg_write(8'h02);
    @(negedge clk);
    repeat (100) @(negedge clk);
    reg_write(8'h02);
    count_until(0, 1'b0, n);
    check(n + 1 == CALN + 2, "R8 calibration restarted", n + 1, CALN + 2);
    settle_idle();

    // abort of a running conversion (R9)
    conv_busy = 1'b1;
    reg_write(8'h02);
    check(conv_abort == 1'b1, "R9 abort on busy sequencer", conv_abort, 1);
    @(negedge clk);
    check(conv_abort == 1'b0 && conv_inhibit == 1'b1, "R9 abort is one cycle", conv_abort, 0);
    conv_busy = 1'b0;
    count_until(0, 1'b0, n);
    reg_write(8'h02);
    check(conv_abort == 1'b1, "R9 abort of appended conversion", conv_abort, 1);
    @(negedge clk);
    check(conv_inhibit == 1'b1, "R9 calibration after abort", conv_inhibit, 1);

    // power fail in the middle of calibration (R2)
    repeat (20) @(negedge clk);
    pwr_fail = 1'b1;
    repeat (3) @(negedge clk);
    check(conv_inhibit == 1'b0 && busy_n == 1'b0, "R2 hold in settle", conv_inhibit, 0);
    pwr_fail = 1'b0;
    count_until(0, 1'b1, n);
    check(n == SETTLE, "R2 settle after power fail", n, SETTLE);
    settle_idle();
    check(busy_n == 1'b1, "R2 returns to idle", busy_n, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule